// File: doc/BRIEF.md
# Two-Level Lookahead Adder, 16 Bits

This block adds two 16-bit unsigned operands and a carry-in in pure combinational logic. The carry chain never ripples. The word is cut into four 4-bit slices. Each slice forms per-bit generate and propagate terms and computes its own internal carries as flat sum-of-products expressions over those terms. A second lookahead unit of the same shape takes the four slice-level propagate and generate pairs and computes the carry into slices 1, 2 and 3 and the final carry-out.

The adder also exposes a word-level propagate and generate pair. A wider adder can then place several of these blocks under a third lookahead level, without waiting for each block's carry-out. The block has no clock and no state, so every output follows its inputs within the same cycle.

Top module: `cla16_adder`

## Requirements
- R1: `sum_out` equals the low 16 bits of `a_in + b_in + carry_in`, taken as unsigned integers.
- R2: `carry_out` equals bit 16 of `a_in + b_in + carry_in`.
- R3: `word_prop` is 1 exactly when every bit position i has `a_in[i] | b_in[i]` equal to 1. Per-bit propagate is the OR of the two operand bits.
- R4: `word_gen` is 1 exactly when `a_in + b_in`, with no carry-in, is at least 65536. Per-bit generate is the AND of the two operand bits.
- R5: `carry_out` always equals `word_gen | (word_prop & carry_in)`, so the pair is enough for an outer lookahead level.
- R6: Each 4-bit slice of `sum_out` (bits 3:0, 7:4, 11:8, 15:12) equals the matching slice of `a_in` plus that of `b_in` plus the true carry out of all lower bits, modulo 16.
- R7: A carry entering at bit 0 travels through all four slices. `a_in = 16'hFFFF`, `b_in = 0` and `carry_in = 1` give `sum_out = 0` and `carry_out = 1`. The same operands with `carry_in = 0` give `sum_out = 16'hFFFF` and `carry_out = 0`.
- R8: The block has no storage. Outputs depend only on the present inputs, and all-zero inputs give all-zero outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 16 | First operand |
| b_in | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Sum bits |
| carry_out | output | 1 | Carry out of bit 15 |
| word_prop | output | 1 | Word-level propagate for an outer lookahead |
| word_gen | output | 1 | Word-level generate for an outer lookahead |

## Verification
Every result is due in the same cycle as its stimulus, with zero register stages: sum, carry-out and the word-level pair all settle once the operands and carry-in are applied. The bench changes inputs only at the falling clock edge and reads all four outputs a short delay later, well before the next rising edge. Each check therefore sees settled values for the current vector only. Expected values come from a bit-serial ripple model and from direct OR/AND reductions of the operands. Neither shares structure with the lookahead trees.

// File: rtl/cla_pkg.sv
package cla_pkg;
  // Default slice width and slice count of the two-level adder
  localparam int unsigned SLICE_W_DEF  = 4;
  localparam int unsigned SLICE_N_DEF  = 4;
  localparam int unsigned WORD_W_DEF   = SLICE_W_DEF * SLICE_N_DEF;
endpackage

// File: rtl/cla_lookahead.sv
// Flat lookahead unit: from N generate/propagate pairs and a carry-in,
// forms every carry in two levels (AND of products, then OR), plus the
// collective propagate/generate of the N positions.
module cla_lookahead #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prop_i,
  input  logic         cin_i,
  output logic [N:1]   carry_o,
  output logic         grp_prop_o,
  output logic         grp_gen_o
);

  // Carry j+1 = OR over k<=j of (gen[k] & prop[k+1..j]) | (cin & prop[0..j])
  always_comb begin
    logic acc;
    logic prod;
    for (int j = 0; j < N; j++) begin
      acc = 1'b0;
      for (int k = 0; k <= j; k++) begin
        prod = gen_i[k];
        for (int m = k + 1; m <= j; m++) begin
          prod = prod & prop_i[m];
        end
        acc = acc | prod;
      end
      prod = cin_i;
      for (int m = 0; m <= j; m++) begin
        prod = prod & prop_i[m];
      end
      carry_o[j+1] = acc | prod;
    end
  end

  // Collective generate: some position generates and all above it propagate
  always_comb begin
    logic acc;
    logic prod;
    acc = 1'b0;
    for (int k = 0; k < N; k++) begin
      prod = gen_i[k];
      for (int m = k + 1; m < N; m++) begin
        prod = prod & prop_i[m];
      end
      acc = acc | prod;
    end
    grp_gen_o = acc;
  end

  assign grp_prop_o = &prop_i;

  // Each flat carry must agree with the one-step recurrence on its neighbour
  always_comb begin
    logic prev;
    for (int j = 0; j < N; j++) begin
      prev = (j == 0) ? cin_i : carry_o[j];
      // R6
      carry_step_chk: assert (carry_o[j+1] == (gen_i[j] | (prop_i[j] & prev)))
        else $error("carry recurrence broken at position %0d", j);
    end
  end

  // R5
  always_comb begin
    group_pair_chk: assert (carry_o[N] == (grp_gen_o | (grp_prop_o & cin_i)))
      else $error("collective pair does not explain the top carry");
  end

endmodule

// File: rtl/cla_slice.sv
// One slice of the adder: bit generate/propagate, local lookahead, sum XOR.
module cla_slice #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         prop_o,
  output logic         gen_o
);

  logic [W-1:0] bit_gen;
  logic [W-1:0] bit_prop;
  logic [W:1]   bit_carry;
  logic [W-1:0] carry_into;
  logic         unused_top;

  assign bit_gen  = a_i & b_i;
  assign bit_prop = a_i | b_i;

  cla_lookahead #(.N(W)) u_local_la (
    .gen_i      (bit_gen),
    .prop_i     (bit_prop),
    .cin_i      (cin_i),
    .carry_o    (bit_carry),
    .grp_prop_o (prop_o),
    .grp_gen_o  (gen_o)
  );

  generate
    if (W > 1) begin : g_wide
      assign carry_into = {bit_carry[W-1:1], cin_i};
    end else begin : g_single
      assign carry_into = cin_i;
    end
  endgenerate

  assign unused_top = bit_carry[W];
  assign sum_o      = a_i ^ b_i ^ carry_into;

  // R6
  always_comb begin
    slice_sum_chk: assert (sum_o == W'((a_i + b_i) + {{(W-1){1'b0}}, cin_i}))
      else $error("slice sum wrong");
  end

endmodule

// File: rtl/cla16_adder.sv
// Two-level carry-lookahead adder: slices plus a second lookahead level.
module cla16_adder
  import cla_pkg::*;
#(
  parameter int unsigned SLICE_W = SLICE_W_DEF,
  parameter int unsigned SLICE_N = SLICE_N_DEF,
  localparam int unsigned WORD_W = SLICE_W * SLICE_N
) (
  input  logic [WORD_W-1:0] a_in,
  input  logic [WORD_W-1:0] b_in,
  input  logic              carry_in,
  output logic [WORD_W-1:0] sum_out,
  output logic              carry_out,
  output logic              word_prop,
  output logic              word_gen
);

  logic [SLICE_N-1:0] slice_prop;
  logic [SLICE_N-1:0] slice_gen;
  logic [SLICE_N:1]   upper_carry;
  logic [SLICE_N-1:0] slice_cin;

  generate
    if (SLICE_N > 1) begin : g_multi
      assign slice_cin = {upper_carry[SLICE_N-1:1], carry_in};
    end else begin : g_one
      assign slice_cin = carry_in;
    end

    for (genvar s = 0; s < SLICE_N; s++) begin : g_slice
      cla_slice #(.W(SLICE_W)) u_slice (
        .a_i    (a_in[s*SLICE_W +: SLICE_W]),
        .b_i    (b_in[s*SLICE_W +: SLICE_W]),
        .cin_i  (slice_cin[s]),
        .sum_o  (sum_out[s*SLICE_W +: SLICE_W]),
        .prop_o (slice_prop[s]),
        .gen_o  (slice_gen[s])
      );
    end
  endgenerate

  cla_lookahead #(.N(SLICE_N)) u_upper_la (
    .gen_i      (slice_gen),
    .prop_i     (slice_prop),
    .cin_i      (carry_in),
    .carry_o    (upper_carry),
    .grp_prop_o (word_prop),
    .grp_gen_o  (word_gen)
  );

  assign carry_out = upper_carry[SLICE_N];

  // R1 R2
  always_comb begin
    word_sum_chk: assert ({carry_out, sum_out} ==
                          ((WORD_W+1)'(a_in) + (WORD_W+1)'(b_in) + (WORD_W+1)'(carry_in)))
      else $error("word sum disagrees with integer addition");
  end

  // R3
  always_comb begin
    word_prop_chk: assert (word_prop == (&(a_in | b_in)))
      else $error("word propagate wrong");
  end

endmodule

// File: tb/test_cla16_adder.sv
module test_cla16_adder;

  logic        clk;
  logic [15:0] a_in, b_in;
  logic        carry_in;
  logic [15:0] sum_out;
  logic        carry_out, word_prop, word_gen;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  cla16_adder i_cla16_adder (
    .a_in      (a_in),
    .b_in      (b_in),
    .carry_in  (carry_in),
    .sum_out   (sum_out),
    .carry_out (carry_out),
    .word_prop (word_prop),
    .word_gen  (word_gen)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Bit-serial reference: returns {carry, sum}
  function automatic logic [16:0] ripple_add(logic [15:0] a, logic [15:0] b, logic c0);
    logic [15:0] s;
    logic c;
    c = c0;
    for (int i = 0; i < 16; i++) begin
      s[i] = a[i] ^ b[i] ^ c;
      c    = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
    end
    return {c, s};
  endfunction

  function automatic logic every_bit_set(logic [15:0] a, logic [15:0] b);
    logic r;
    r = 1'b1;
    for (int i = 0; i < 16; i++) r = r & (a[i] | b[i]);
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h", req, a_in, b_in, carry_in, act, exp);
    end
  endtask

  task automatic apply_and_check(logic [15:0] a, logic [15:0] b, logic c);
    logic [16:0] full;
    logic [16:0] nocin;
    logic [16:0] part;
    @(negedge clk);
    a_in = a; b_in = b; carry_in = c;
    #2;
    full  = ripple_add(a, b, c);
    nocin = ripple_add(a, b, 1'b0);
    check("R1 sum", 32'(sum_out), 32'(full[15:0]));
    check("R2 carry", 32'(carry_out), 32'(full[16]));
    check("R3 word_prop", 32'(word_prop), 32'(every_bit_set(a, b)));
    check("R4 word_gen", 32'(word_gen), 32'(nocin[16]));
    check("R5 pair", 32'(carry_out), 32'(word_gen | (word_prop & c)));
    for (int s = 0; s < 4; s++) begin
      // carry out of the bits below slice s
      part = (s == 0) ? 17'(c) : 17'(ripple_add(a & ((16'h1 << (4*s)) - 1),
                                                 b & ((16'h1 << (4*s)) - 1), c) >> (4*s));
      check("R6 slice", 32'(sum_out[4*s +: 4]),
            32'(4'(a[4*s +: 4] + b[4*s +: 4] + part[0])));
    end
  endtask

  initial begin
    int cycles;
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        done = 1;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    a_in = '0; b_in = '0; carry_in = 1'b0;
    void'($urandom(32'd20250611));
    // R8: idle inputs give quiet outputs
    @(negedge clk); #2;
    check("R8 zero sum", 32'(sum_out), 32'h0);
    check("R8 zero carry", 32'(carry_out), 32'h0);
    check("R8 zero prop", 32'(word_prop), 32'h0);
    check("R8 zero gen", 32'(word_gen), 32'h0);
    // R7: carry runs through all slices
    apply_and_check(16'hFFFF, 16'h0000, 1'b1);
    check("R7 full ripple sum", 32'(sum_out), 32'h0);
    check("R7 full ripple carry", 32'(carry_out), 32'h1);
    apply_and_check(16'hFFFF, 16'h0000, 1'b0);
    check("R7 no carry sum", 32'(sum_out), 32'hFFFF);
    check("R7 no carry carry", 32'(carry_out), 32'h0);
    apply_and_check(16'hFFFF, 16'h0001, 1'b0);
    apply_and_check(16'hFFFF, 16'hFFFF, 1'b1);
    apply_and_check(16'hAAAA, 16'h5555, 1'b0);
    apply_and_check(16'hAAAA, 16'h5555, 1'b1);
    apply_and_check(16'h5555, 16'h5555, 1'b1);
    apply_and_check(16'hAAAA, 16'hAAAA, 1'b0);
    apply_and_check(16'h0FFF, 16'h0001, 1'b0);
    apply_and_check(16'h00F0, 16'h0010, 1'b1);
    apply_and_check(16'h8000, 16'h8000, 1'b0);
    apply_and_check(16'hF0F0, 16'h0F0F, 1'b1);
    // R8: same operands again give same results
    apply_and_check(16'h1234, 16'hFEDC, 1'b0);
    apply_and_check(16'h1234, 16'hFEDC, 1'b0);
    for (int n = 0; n < 2000; n++) begin
      apply_and_check(16'($urandom), 16'($urandom), 1'($urandom));
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule